// File: doc/BRIEF.md
# Double-Buffered Serial DAC Input Register

This block is the digital front end of a 12-bit voltage-output DAC. A host shifts a word in serially, most significant bit first. It uses a serial clock that idles high, a data line and an active-low select. The bits go into an input shift register that holds only the most recent 12 bits. A host that sends a 16-clock frame of two bytes therefore loses the first four bits over the top, and the low 12 bits of the frame remain.

The shifted word reaches the converter only when the host pulls a separate active-low load strobe. An active-low clear zeroes the converter register at once, with no clock needed. The clear leaves the shift register as it was, so a later load can still transfer the word that was shifted in before the clear. All serial and strobe pins are asynchronous to the system clock. They are synchronized and edge-detected in the system clock domain, which must run several times faster than the serial clock.

Top module: `serdac_front`

## Requirements
- R1: After reset, `dacCode` is 0.
- R2: Each rising edge of `sclkIn` seen while `csN` is low shifts `sdiIn` into the shift register, MSB first. A falling edge of `ldN` then makes `dacCode` equal to the last 12 bits shifted in.
- R3: In a 16-clock frame, the first four bits are discarded. `dacCode` after load equals the low 12 bits of the 16-bit frame word.
- R4: For any frame length from 12 to 16 clocks, `dacCode` after load equals the last 12 bits of the frame.
- R5: Rising edges of `sclkIn` while `csN` is high do not shift. This includes `csN` rising while `sclkIn` is already high at the end of a frame.
- R6: `dacCode` changes only on a falling edge of `ldN` (or on a clear). Shifting a frame alone leaves it unchanged.
- R7: `clrN` low forces `dacCode` to 0 asynchronously, before any `clk` edge.
- R8: `clrN` has priority over `ldN`. A load strobe while `clrN` is low leaves `dacCode` at 0.
- R9: `clrN` does not clear the shift register. A load after the clear is released transfers the word shifted in before the clear.
- R10: A frame of all ones yields the full-scale code 0xFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the serial pins |
| rstN | input | 1 | Active-low asynchronous reset |
| sclkIn | input | 1 | Serial clock, idles high, data taken on rising edge |
| sdiIn | input | 1 | Serial data, MSB first |
| csN | input | 1 | Active-low select that gates shifting |
| ldN | input | 1 | Active-low load strobe, falling edge transfers the word |
| clrN | input | 1 | Active-low asynchronous clear of the DAC register |
| dacCode | output | 12 | DAC register value driving the converter core |

## Verification
Frames of every length from 12 to 16 clocks are sent, each with distinct bits above the low 12. A wrong window, a dropped bit or an extra end-of-frame shift therefore gives a different code. Alternating patterns and all ones separate the MSB-first order and the full-scale code from stuck or reversed bits. Serial clock edges with select high, and load strobes given during a clear, check that the register ignores these events. A load after the clear is released tells a cleared shift register apart from a preserved one.

// File: rtl/serdac_pkg.sv
package serdac_pkg;
  typedef struct packed {
    logic shiftEn;
    logic loadEn;
  } ctrlStrobes_t;
endpackage

// File: rtl/serdac_sync.sv
module serdac_sync #(
  parameter int WIDTH = 4,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
  input  logic clk,
  input  logic rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);
  logic [WIDTH-1:0] chain [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) chain[s] <= RESET_VAL;
      else if (s == 0) chain[s] <= asyncIn;
      else chain[s] <= chain[(s == 0) ? 0 : s-1];
    end
  end

  assign syncOut = chain[STAGES-1];
endmodule

// File: rtl/serdac_ctrl.sv
module serdac_ctrl
  import serdac_pkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  logic sclkSync,
  input  logic csSync,
  input  logic ldSync,
  input  logic clrSync,
  output ctrlStrobes_t strobes
);
  logic sclkPrev;
  logic ldPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclkPrev <= 1'b1;
      ldPrev   <= 1'b1;
    end else begin
      sclkPrev <= sclkSync;
      ldPrev   <= ldSync;
    end
  end

  always_comb begin
    strobes.shiftEn = sclkSync && !sclkPrev && !csSync;
    strobes.loadEn  = !ldSync && ldPrev && clrSync;
  end
endmodule

// File: rtl/serdac_datapath.sv
module serdac_datapath
  import serdac_pkg::*;
#(
  parameter int DATA_W = 12
) (
  input  logic clk,
  input  logic rstN,
  input  logic dacClrN,
  input  logic sdiBit,
  input  ctrlStrobes_t strobes,
  output logic [DATA_W-1:0] shiftWord,
  output logic [DATA_W-1:0] dacWord
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) shiftWord <= '0;
    else if (strobes.shiftEn) shiftWord <= {shiftWord[DATA_W-2:0], sdiBit};
  end

  always_ff @(posedge clk or negedge dacClrN) begin
    if (!dacClrN) dacWord <= '0;
    else if (strobes.loadEn) dacWord <= shiftWord;
  end
endmodule

// File: rtl/serdac_front.sv
module serdac_front
  import serdac_pkg::*;
#(
  parameter int DATA_W = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic sclkIn,
  input  logic sdiIn,
  input  logic csN,
  input  logic ldN,
  input  logic clrN,
  output logic [DATA_W-1:0] dacCode
);
  localparam int PIN_N = 5;
  localparam logic [PIN_N-1:0] PIN_IDLE = 5'b11110;

  logic [PIN_N-1:0] pinSync;
  logic sdiSync, sclkSync, csSync, ldSync, clrSync;
  logic dacClrN;
  ctrlStrobes_t strobes;
  logic [DATA_W-1:0] shiftWord;

  serdac_sync #(.WIDTH(PIN_N), .STAGES(SYNC_STAGES), .RESET_VAL(PIN_IDLE)) u_sync (
    .clk(clk), .rstN(rstN),
    .asyncIn({clrN, ldN, csN, sclkIn, sdiIn}),
    .syncOut(pinSync)
  );
  assign {clrSync, ldSync, csSync, sclkSync, sdiSync} = pinSync;

  serdac_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .sclkSync(sclkSync), .csSync(csSync),
    .ldSync(ldSync), .clrSync(clrSync), .strobes(strobes)
  );

  assign dacClrN = rstN & clrN;

  serdac_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .dacClrN(dacClrN), .sdiBit(sdiSync),
    .strobes(strobes), .shiftWord(shiftWord), .dacWord(dacCode)
  );
endmodule

// File: rtl/serdac_checker.sv
module serdac_checker #(
  parameter int DATA_W = 12
) (
  input logic clk,
  input logic rstN,
  input logic clrN,
  input logic [DATA_W-1:0] dacCode,
  input logic shiftEn,
  input logic loadEn,
  input logic csHigh,
  input logic sdiBit,
  input logic [DATA_W-1:0] shiftWord
);
  a_r7_clear_zero: assert property (@(posedge clk) disable iff (!rstN)
    !clrN |-> dacCode == '0);

  a_r2_load_copies: assert property (@(posedge clk) disable iff (!rstN)
    loadEn |=> (!clrN || dacCode == $past(shiftWord)));

  a_r6_hold_without_load: assert property (@(posedge clk) disable iff (!rstN)
    (clrN && !loadEn) |=> (!clrN || $stable(dacCode)));

  a_r5_no_shift_deselected: assert property (@(posedge clk) disable iff (!rstN)
    csHigh |=> $stable(shiftWord));

  a_r2_shift_step: assert property (@(posedge clk) disable iff (!rstN)
    shiftEn |=> shiftWord == {$past(shiftWord[DATA_W-2:0]), $past(sdiBit)});
endmodule

bind serdac_front serdac_checker #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rstN(rstN), .clrN(clrN), .dacCode(dacCode),
  .shiftEn(strobes.shiftEn), .loadEn(strobes.loadEn), .csHigh(csSync),
  .sdiBit(sdiSync), .shiftWord(shiftWord)
);

// File: tb/serdac_front_tb.sv
module serdac_front_tb;
  logic clk = 0;
  logic rstN = 0;
  logic sclkIn = 1, sdiIn = 0, csN = 1, ldN = 1, clrN = 1;
  logic [11:0] dacCode;
  int checks = 0;
  int fails = 0;

  always #10 clk = ~clk;

  serdac_front u_dut (
    .clk(clk), .rstN(rstN), .sclkIn(sclkIn), .sdiIn(sdiIn),
    .csN(csN), .ldN(ldN), .clrN(clrN), .dacCode(dacCode)
  );

  task automatic check(input string req, input logic [11:0] got, input logic [11:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sendBits(input logic [15:0] word, input int n);
    csN = 0;
    waitCyc(4);
    for (int i = n - 1; i >= 0; i--) begin
      sclkIn = 0;
      sdiIn = word[i];
      waitCyc(4);
      sclkIn = 1;
      waitCyc(4);
    end
    csN = 1;
    waitCyc(6);
  endtask

  task automatic pulseLoad();
    ldN = 0;
    waitCyc(6);
    ldN = 1;
    waitCyc(6);
  endtask

  task automatic testReset();
    check("R1 reset", dacCode, 12'h000);
  endtask

  task automatic testFullFrame();
    sendBits(16'hA5C3, 16);
    check("R6 no update before load", dacCode, 12'h000);
    pulseLoad();
    check("R3 16-clock frame low bits", dacCode, 12'h5C3);
    check("R2 MSB-first shift and load", dacCode, 12'h5C3);
  endtask

  task automatic testLengths();
    for (int n = 12; n <= 16; n++) begin
      logic [15:0] w;
      w = 16'h9E00 ^ (16'h0137 * n[15:0]);
      sendBits(w, n);
      pulseLoad();
      check($sformatf("R4 frame of %0d clocks", n), dacCode, w[11:0]);
    end
  endtask

  task automatic testFullScale();
    sendBits(16'hFFFF, 16);
    pulseLoad();
    check("R10 full scale", dacCode, 12'hFFF);
  endtask

  task automatic testDeselected();
    sendBits(16'h0AAA, 16);
    for (int i = 0; i < 6; i++) begin
      sclkIn = 0;
      sdiIn = i[0];
      waitCyc(4);
      sclkIn = 1;
      waitCyc(4);
    end
    pulseLoad();
    check("R5 edges with select high ignored", dacCode, 12'hAAA);
    sendBits(16'h0555, 12);
    check("R6 held after shift without load", dacCode, 12'hAAA);
    pulseLoad();
    check("R5 no extra shift at select rise", dacCode, 12'h555);
  endtask

  task automatic testClear();
    sendBits(16'h0123, 12);
    pulseLoad();
    check("R2 load before clear", dacCode, 12'h123);
    #3 clrN = 0;
    #1;
    check("R7 asynchronous clear", dacCode, 12'h000);
    waitCyc(4);
    pulseLoad();
    check("R8 load ignored during clear", dacCode, 12'h000);
    clrN = 1;
    waitCyc(6);
    check("R8 stays zero after clear release", dacCode, 12'h000);
    pulseLoad();
    check("R9 shift register kept through clear", dacCode, 12'h123);
  endtask

  initial begin
    #(200000 * 20);
    fails++;
    checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    waitCyc(3);
    rstN = 1;
    waitCyc(4);
    testReset();
    testFullFrame();
    testLengths();
    testFullScale();
    testDeselected();
    testClear();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule